// File: doc/BRIEF.md
# Charger Status LED Pattern Generator

This block turns the charger's current status category into a drive pattern for a single status LED sink. Every category maps to one of four patterns: dark, a fast blink at 2 Hz, a slow blink at 1 Hz, or solid on. Both blinks run at 50 % duty. A mapping-select input chooses between two tables. The tables differ only in how fault categories are shown: they blink fast in one table and stay dark in the other.

Both blink rates come from one divider. That divider produces a quarter-second tick from a system clock whose frequency is a parameter. A 2-bit phase counter, advanced by that tick, times both blinks. When the status category changes, the divider and the phase counter restart, so each new pattern begins with a full on half-period. The block also registers a 2-bit sink-current code and passes it to the analog sink, which is not part of this block.

Top module: `chg_led_status`

## Requirements
- R1: While `rst` is high at a clock edge, `led_en_o` and `led_ilvl_o` are both 0 after that edge, whatever the other inputs are.
- R2: Categories 0 (no input), 1 (suspended) and 2 (buck only, not charging) keep `led_en_o` at 0 in both mapping tables.
- R3: With `map_sel_i` = 0, fault categories 10 (charge timer expired), 11 (battery temperature out of range) and 12 (thermal shutdown) blink at 2 Hz and 50 % duty: on for CLK_HZ/4 cycles, then off for CLK_HZ/4 cycles.
- R4: With `map_sel_i` = 1, fault categories 10, 11 and 12 keep `led_en_o` at 0.
- R5: Charging categories 3 (dead battery), 4 (prequalification), 5 (constant current) and 6 (constant voltage) blink at 1 Hz and 50 % duty in both tables: on for CLK_HZ/2 cycles, then off for CLK_HZ/2 cycles.
- R6: Categories 7 (top-off), 8 (done) and 9 (restart) hold `led_en_o` at 1 in both tables.
- R7: A change of `chg_cat_i` takes effect at the first clock edge that samples it and restarts the blink timing. A blinking pattern therefore starts with a complete on half-period, even when the change is to another category that uses the same pattern.
- R8: Unused category codes 13, 14 and 15 keep `led_en_o` at 0 in both tables.
- R9: `led_ilvl_o` shows the value `led_cur_i` had at the previous clock edge. Code n selects a sink current of 5 mA × (n + 1), so 0 selects 5 mA and 3 selects 20 mA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst | input | 1 | Synchronous active-high reset |
| chg_cat_i | input | 4 | Charger status category code |
| map_sel_i | input | 1 | Mapping table select: 0 = faults blink, 1 = faults dark |
| led_cur_i | input | 2 | Requested sink-current code |
| led_en_o | output | 1 | Registered LED sink enable |
| led_ilvl_o | output | 2 | Registered sink-current code |

## Verification
Every output is one register stage away from the inputs. A new category, mapping select or current code is therefore visible after the first rising edge that samples it. The bench drives each input on a falling edge, lets one rising edge pass, and takes sample 0 on the next falling edge. From that sample on it predicts the LED value cycle by cycle: a fast blink is on for CLK_HZ/4 samples and then off for the same number, and a slow blink does the same with CLK_HZ/2. Each window is scored as one check. The bench shortens the clock parameter to 400 Hz, so a whole slow period lasts 400 cycles, and it compares every sample across two full periods.

// File: rtl/led_stat_pkg.sv
package led_stat_pkg;

  typedef enum logic [3:0] {
    CAT_NO_INPUT   = 4'd0,
    CAT_SUSPEND    = 4'd1,
    CAT_BUCK_ONLY  = 4'd2,
    CAT_DEAD_BATT  = 4'd3,
    CAT_PREQUAL    = 4'd4,
    CAT_FAST_CC    = 4'd5,
    CAT_FAST_CV    = 4'd6,
    CAT_TOPOFF     = 4'd7,
    CAT_DONE       = 4'd8,
    CAT_RESTART    = 4'd9,
    CAT_TIMEOUT    = 4'd10,
    CAT_TEMP_OFF   = 4'd11,
    CAT_THERM_SHDN = 4'd12
  } chg_cat_e;

  typedef enum logic [1:0] {
    PAT_OFF   = 2'd0,
    PAT_FAST  = 2'd1,
    PAT_SLOW  = 2'd2,
    PAT_SOLID = 2'd3
  } led_pat_e;

endpackage

// File: rtl/led_pat_map.sv
module led_pat_map
  import led_stat_pkg::*;
#(
  parameter int CAT_W = 4
) (
  input  logic [CAT_W-1:0] cat_i,
  input  logic             map_sel_i,
  output led_pat_e         pat_o
);

  always_comb begin
    case (cat_i)
      CAT_DEAD_BATT, CAT_PREQUAL, CAT_FAST_CC, CAT_FAST_CV:
        pat_o = PAT_SLOW;
      CAT_TOPOFF, CAT_DONE, CAT_RESTART:
        pat_o = PAT_SOLID;
      CAT_TIMEOUT, CAT_TEMP_OFF, CAT_THERM_SHDN:
        pat_o = map_sel_i ? PAT_OFF : PAT_FAST;
      default:
        pat_o = PAT_OFF;
    endcase
  end

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int QTR_CYC = 250000,
  parameter int PH_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart_i,
  output logic [PH_W-1:0] ph_nxt_o
);

  localparam int DIV_W = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
  localparam logic [DIV_W-1:0] DIV_TC = DIV_W'(QTR_CYC - 1);

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  ph_q;
  logic [DIV_W-1:0] div_nxt;
  logic             qtr_tick;

  assign qtr_tick = (div_q == DIV_TC);

  always_comb begin
    if (restart_i) begin
      div_nxt  = '0;
      ph_nxt_o = '0;
    end else if (qtr_tick) begin
      div_nxt  = '0;
      ph_nxt_o = ph_q + PH_W'(1);
    end else begin
      div_nxt  = div_q + DIV_W'(1);
      ph_nxt_o = ph_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ph_q  <= '0;
    end else begin
      div_q <= div_nxt;
      ph_q  <= ph_nxt_o;
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_q <= DIV_TC);

  // R7
  restart_phase_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (ph_q == '0 && div_q == '0));

endmodule

// File: rtl/chg_led_status.sv
module chg_led_status
  import led_stat_pkg::*;
#(
  parameter int CLK_HZ = 1000000,
  parameter int CAT_W  = 4,
  parameter int ILVL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CAT_W-1:0]  chg_cat_i,
  input  logic              map_sel_i,
  input  logic [ILVL_W-1:0] led_cur_i,
  output logic              led_en_o,
  output logic [ILVL_W-1:0] led_ilvl_o
);

  localparam int QTR_CYC = (CLK_HZ / 4 < 2) ? 2 : CLK_HZ / 4;
  localparam int PH_W    = 2;

  logic [CAT_W-1:0] cat_prev_q;
  logic             restart;
  led_pat_e         pat;
  logic [PH_W-1:0]  ph_nxt;
  logic             led_on;

  assign restart = (chg_cat_i != cat_prev_q);

  led_pat_map #(.CAT_W(CAT_W)) map_i (
    .cat_i     (chg_cat_i),
    .map_sel_i (map_sel_i),
    .pat_o     (pat)
  );

  led_blink_timer #(.QTR_CYC(QTR_CYC), .PH_W(PH_W)) tmr_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .ph_nxt_o  (ph_nxt)
  );

  always_comb begin
    case (pat)
      PAT_FAST:  led_on = ~ph_nxt[0];
      PAT_SLOW:  led_on = ~ph_nxt[1];
      PAT_SOLID: led_on = 1'b1;
      default:   led_on = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cat_prev_q <= '0;
      led_en_o   <= 1'b0;
      led_ilvl_o <= '0;
    end else begin
      cat_prev_q <= chg_cat_i;
      led_en_o   <= led_on;
      led_ilvl_o <= led_cur_i;
    end
  end

  // R1
  rst_dark_chk: assert property (@(posedge clk)
    rst |=> (led_en_o == 1'b0 && led_ilvl_o == '0));

  // R2
  idle_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_cat_i <= CAT_W'(2)) |=> !led_en_o);

  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (map_sel_i && chg_cat_i >= CAT_W'(10) && chg_cat_i <= CAT_W'(12)) |=> !led_en_o);

  // R6
  solid_on_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_cat_i >= CAT_W'(7) && chg_cat_i <= CAT_W'(9)) |=> led_en_o);

  // R8
  unused_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_cat_i >= CAT_W'(13)) |=> !led_en_o);

  // R9
  ilvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (led_ilvl_o == $past(led_cur_i)));

endmodule

// File: tb/chg_led_status_tb_top.sv
module chg_led_status_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 400;
  localparam int Q          = CLK_HZ / 4;
  localparam int WD_LIMIT   = 100000;

  localparam int K_OFF   = 0;
  localparam int K_FAST  = 1;
  localparam int K_SLOW  = 2;
  localparam int K_SOLID = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] chg_cat_i = 4'd0;
  logic       map_sel_i = 1'b0;
  logic [1:0] led_cur_i = 2'd0;
  logic       led_en_o;
  logic [1:0] led_ilvl_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chg_led_status #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .chg_cat_i  (chg_cat_i),
    .map_sel_i  (map_sel_i),
    .led_cur_i  (led_cur_i),
    .led_en_o   (led_en_o),
    .led_ilvl_o (led_ilvl_o)
  );

  function automatic bit exp_led(int kind, int i);
    case (kind)
      K_FAST:  return ((i / Q) % 2) == 0;
      K_SLOW:  return ((i / (2 * Q)) % 2) == 0;
      K_SOLID: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // drive at a falling edge, pass one rising edge, sample 0 at next falling edge
  task automatic apply_cat(input logic [3:0] cat);
    @(negedge clk);
    chg_cat_i = cat;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_window(input int kind, input int n, input string req);
    int bad_i = -1;
    bit bad_v = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (led_en_o !== exp_led(kind, i) && bad_i < 0) begin
        bad_i = i;
        bad_v = led_en_o;
      end
    end
    n_chk++;
    if (bad_i >= 0) begin
      n_fail++;
      $display("FAIL %s cat=%0d sel=%0d sample %0d: actual led_en=%0b expected %0b",
               req, chg_cat_i, map_sel_i, bad_i, bad_v, exp_led(kind, bad_i));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    chg_cat_i = 4'd8;
    led_cur_i = 2'd3;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (led_en_o !== 1'b0 || led_ilvl_o !== 2'd0) begin
      n_fail++;
      $display("FAIL R1: actual led_en=%0b ilvl=%0d expected 0 0", led_en_o, led_ilvl_o);
    end
    chg_cat_i = 4'd0;
    led_cur_i = 2'd0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_idle();
    for (int s = 0; s < 2; s++) begin
      map_sel_i = s[0];
      for (int c = 0; c < 3; c++) begin
        apply_cat(4'(c));
        check_window(K_OFF, 4 * Q, "R2");
      end
    end
  endtask

  task automatic t_fault_blink();
    map_sel_i = 1'b0;
    for (int c = 10; c <= 12; c++) begin
      apply_cat(4'(c));
      check_window(K_FAST, 4 * Q, "R3");
    end
  endtask

  task automatic t_fault_dark();
    map_sel_i = 1'b1;
    for (int c = 10; c <= 12; c++) begin
      apply_cat(4'(c));
      check_window(K_OFF, 4 * Q, "R4");
    end
  endtask

  task automatic t_charging();
    for (int s = 0; s < 2; s++) begin
      map_sel_i = s[0];
      for (int c = 3; c <= 6; c++) begin
        apply_cat(4'(c));
        check_window(K_SLOW, 8 * Q, "R5");
      end
    end
  endtask

  task automatic t_complete();
    for (int s = 0; s < 2; s++) begin
      map_sel_i = s[0];
      for (int c = 7; c <= 9; c++) begin
        apply_cat(4'(c));
        check_window(K_SOLID, 2 * Q, "R6");
      end
    end
  endtask

  task automatic t_restart();
    map_sel_i = 1'b0;
    // slow to slow: switch inside the off half
    apply_cat(4'd4);
    repeat (2 * Q + 30) @(negedge clk);
    apply_cat(4'd5);
    check_window(K_SLOW, 8 * Q, "R7");
    // slow to fast: switch midway through the on half
    repeat (Q) @(negedge clk);
    apply_cat(4'd10);
    check_window(K_FAST, 4 * Q, "R7");
    // fast to slow: switch late in an off half
    repeat (Q + 70) @(negedge clk);
    apply_cat(4'd3);
    check_window(K_SLOW, 4 * Q, "R7");
  endtask

  task automatic t_unused();
    for (int s = 0; s < 2; s++) begin
      map_sel_i = s[0];
      for (int c = 13; c <= 15; c++) begin
        apply_cat(4'(c));
        check_window(K_OFF, 2 * Q, "R8");
      end
    end
  endtask

  task automatic t_current();
    for (int k = 0; k < 4; k++) begin
      logic [1:0] code;
      code = 2'(3 - k);
      @(negedge clk);
      led_cur_i = code;
      @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (led_ilvl_o !== code) begin
        n_fail++;
        $display("FAIL R9: actual ilvl=%0d expected %0d (%0d mA)",
                 led_ilvl_o, code, 5 * (code + 1));
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_fault_blink();
    t_fault_dark();
    t_charging();
    t_complete();
    t_restart();
    t_unused();
    t_current();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule